// File: doc/BRIEF.md
# Half-Bridge Fault Status Tracker

This block holds a 2-bit status code for each of a set of half-bridges, together with sticky global fault flags for overcurrent, underload and thermal shutdown and a live thermal warning flag. The comparator bits from the analog sensing arrive one per bridge. Overcurrent is qualified by a separate persistence counter in each bridge. Underload is qualified by one timer that all bridges share. A status-reset pulse, taken from a valid command frame, clears latched faults. The block raises a latch-off request for every bridge that must stop driving.

Each bridge runs a one-way priority state machine. Enabling a bridge moves it from disabled to enabled. From enabled it can drop to underload or to overcurrent, and an underload can still escalate to overcurrent. No path leads from overcurrent back to underload. Clearing the enable bit returns any state to disabled. All pins are plain control and status levels, with no stream handshake. Delays are parameters counted in clock cycles.

Top module: `hb_fault_tracker`

## Requirements
- R1: After reset, every status pair reads 00, all global flags are 0 and no latch-off request is raised.
- R2: Status pair i sits at br_status[2i+1:2i], with 00 = disabled, 11 = enabled, 10 = underload and 01 = overcurrent. One clock after br_en[i] is seen high in the disabled state, the pair reads 11. One clock after br_en[i] is seen low, the pair reads 00 from any state and that bridge's overcurrent/underload latch-off is released.
- R3: While bridge i is enabled or in underload and not latched off, oc_cmp[i] held high on OC_DLY consecutive clock edges makes the pair read 01 after the last of those edges. The same edge sets latch_off[i] and oc_flag. A gap of one cycle restarts the count.
- R4: One shared underload timer runs while at least one bridge is in state 11 with ul_cmp high and no thermal latch. It returns to zero whenever no bridge meets that condition. After UL_DLY running edges, every bridge meeting the condition on that edge moves to 10 and ul_flag is set, so a bridge that joins later waits only for the time that remains.
- R5: When ul_shut_en is 1 as an underload qualifies, latch_off[i] is set and stays set until a status reset or disable. When ul_shut_en is 0, the status still moves to 10 but latch_off[i] stays 0.
- R6: An underload bridge that is still driving moves to 01 on a qualified overcurrent. A bridge at 01 never moves to 10.
- R7: A one-cycle stat_clr pulse moves every bridge at 10 or 01 to 11 and clears oc_flag, ul_flag and the overcurrent/underload latch-offs. If an overcurrent qualifies on the same edge, the overcurrent wins.
- R8: tsd_cmp[i] high sets a per-bridge thermal latch that raises latch_off[i] and tsd_flag without changing the status pair. stat_clr clears that latch only when tsd_cmp[i] is low at that edge.
- R9: tw_flag equals the OR of tw_cmp as sampled on the previous edge, and is not latched.
- R10: oc_flag and ul_flag stay set after the offending bridge is disabled, and clear only on stat_clr or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_en | input | NUM_BR | Per-bridge enable |
| oc_cmp | input | NUM_BR | Per-bridge overcurrent comparator |
| ul_cmp | input | NUM_BR | Per-bridge underload comparator |
| tw_cmp | input | NUM_BR | Per-bridge thermal warning comparator |
| tsd_cmp | input | NUM_BR | Per-bridge thermal shutdown comparator |
| ul_shut_en | input | 1 | Latch bridge off on qualified underload |
| stat_clr | input | 1 | Status reset pulse from a valid frame |
| br_status | output | 2*NUM_BR | Priority-encoded status pairs |
| oc_flag | output | 1 | Sticky global overcurrent flag |
| ul_flag | output | 1 | Sticky global underload flag |
| tsd_flag | output | 1 | Global latched thermal shutdown flag |
| tw_flag | output | 1 | Live global thermal warning flag |
| latch_off | output | NUM_BR | Per-bridge turn-off request |

## Verification
A vector table sweeps several enable and warning patterns, which separates bit placement within the status word from flag behaviour. Directed sequences hold the overcurrent comparator for exactly one edge less than the delay and then for the full delay, and interrupt it once, which pins the persistence counter to the exact cycle. Staggered underloads on two bridges show that they share one timer rather than each running its own. A single interruption shows that the timer restarts. Further sequences drive escalation against the reverse order, underloads with the shutdown control set and clear, a clear on the same edge as an overcurrent, and a clear while the thermal comparator is still high. Each one separates a legal transition from a forbidden one.

// File: rtl/hbft_pkg.sv
package hbft_pkg;
  typedef enum logic [1:0] {
    HB_OFF = 2'b00,
    HB_OCS = 2'b01,
    HB_ULD = 2'b10,
    HB_ON  = 2'b11
  } hb_state_t;
endpackage

// File: rtl/hbft_oc_qual.sv
module hbft_oc_qual #(
  parameter int DLY = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic oc_cmp,
  output logic hit
);
  localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);

  logic [CW-1:0] cnt;

  assign hit = armed && oc_cmp && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!armed || !oc_cmp) cnt <= '0;
    else if (hit)               cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  AST_OC_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ($past(oc_cmp) && $past(armed))); // R3
endmodule

// File: rtl/hbft_ul_timer.sv
module hbft_ul_timer #(
  parameter int N   = 6,
  parameter int DLY = 3500
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] elig,
  output logic         fire
);
  localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);

  logic [CW-1:0] cnt;
  logic          any_elig;

  assign any_elig = |elig;
  assign fire     = any_elig && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!any_elig) cnt <= '0;
    else if (fire)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  AST_UL_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !any_elig |=> (cnt == '0)); // R4
endmodule

// File: rtl/hbft_bridge.sv
module hbft_bridge
  import hbft_pkg::*;
#(
  parameter int OC_DLY = 250
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      oc_cmp,
  input  logic      ul_cmp,
  input  logic      tsd_cmp,
  input  logic      ul_fire,
  input  logic      shut_en,
  input  logic      clr,
  output hb_state_t state,
  output logic      ul_elig,
  output logic      oc_enter,
  output logic      ul_enter,
  output logic      tsd_lat,
  output logic      latch_off
);
  hb_state_t nxt;
  logic      ul_off;
  logic      drive;
  logic      oc_hit;
  logic      ul_hit;

  assign latch_off = (state == HB_OCS) || ul_off || tsd_lat;
  assign drive     = ((state == HB_ON) || (state == HB_ULD)) && !latch_off;
  assign ul_elig   = (state == HB_ON) && ul_cmp && !tsd_lat;
  assign ul_hit    = ul_elig && ul_fire;
  assign oc_enter  = en && oc_hit;
  assign ul_enter  = en && ul_hit && !oc_hit;

  hbft_oc_qual #(.DLY(OC_DLY)) u_oc (
    .clk    (clk),
    .rst_n  (rst_n),
    .armed  (drive),
    .oc_cmp (oc_cmp),
    .hit    (oc_hit)
  );

  always_comb begin
    nxt = state;
    if (!en) begin
      nxt = HB_OFF;
    end else begin
      case (state)
        HB_OFF: nxt = HB_ON;
        HB_ON: begin
          if (oc_hit)      nxt = HB_OCS;
          else if (ul_hit) nxt = HB_ULD;
        end
        HB_ULD: begin
          if (oc_hit)   nxt = HB_OCS;
          else if (clr) nxt = HB_ON;
        end
        HB_OCS: begin
          if (clr) nxt = HB_ON;
        end
        default: nxt = HB_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= HB_OFF;
      ul_off <= 1'b0;
    end else begin
      state  <= nxt;
      ul_off <= (nxt == HB_ULD) && (ul_off || (ul_hit && shut_en));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tsd_lat <= 1'b0;
    else if (tsd_cmp) tsd_lat <= 1'b1;
    else if (clr)     tsd_lat <= 1'b0;
  end

  AST_EN_LOW_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state == HB_OFF)); // R2
  AST_NO_OC_TO_UL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HB_OCS) |=> (state != HB_ULD)); // R6
  AST_TSD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tsd_lat && tsd_cmp) |=> tsd_lat); // R8
  AST_ULD_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == HB_ULD) && en && !clr && !oc_hit) |=> (state == HB_ULD)); // R7
endmodule

// File: rtl/hb_fault_tracker.sv
module hb_fault_tracker
  import hbft_pkg::*;
#(
  parameter int NUM_BR = 6,
  parameter int OC_DLY = 250,
  parameter int UL_DLY = 3500
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_BR-1:0]   br_en,
  input  logic [NUM_BR-1:0]   oc_cmp,
  input  logic [NUM_BR-1:0]   ul_cmp,
  input  logic [NUM_BR-1:0]   tw_cmp,
  input  logic [NUM_BR-1:0]   tsd_cmp,
  input  logic                ul_shut_en,
  input  logic                stat_clr,
  output logic [2*NUM_BR-1:0] br_status,
  output logic                oc_flag,
  output logic                ul_flag,
  output logic                tsd_flag,
  output logic                tw_flag,
  output logic [NUM_BR-1:0]   latch_off
);
  logic [NUM_BR-1:0] ul_elig;
  logic [NUM_BR-1:0] oc_enter;
  logic [NUM_BR-1:0] ul_enter;
  logic [NUM_BR-1:0] tsd_lat;
  logic              ul_fire;

  hbft_ul_timer #(.N(NUM_BR), .DLY(UL_DLY)) u_ult (
    .clk   (clk),
    .rst_n (rst_n),
    .elig  (ul_elig),
    .fire  (ul_fire)
  );

  for (genvar i = 0; i < NUM_BR; i++) begin : g_br
    hb_state_t st;
    hbft_bridge #(.OC_DLY(OC_DLY)) u_br (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (br_en[i]),
      .oc_cmp    (oc_cmp[i]),
      .ul_cmp    (ul_cmp[i]),
      .tsd_cmp   (tsd_cmp[i]),
      .ul_fire   (ul_fire),
      .shut_en   (ul_shut_en),
      .clr       (stat_clr),
      .state     (st),
      .ul_elig   (ul_elig[i]),
      .oc_enter  (oc_enter[i]),
      .ul_enter  (ul_enter[i]),
      .tsd_lat   (tsd_lat[i]),
      .latch_off (latch_off[i])
    );
    assign br_status[2*i +: 2] = st;
  end

  assign tsd_flag = |tsd_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_flag <= 1'b0;
      ul_flag <= 1'b0;
      tw_flag <= 1'b0;
    end else begin
      oc_flag <= (oc_flag && !stat_clr) || (|oc_enter);
      ul_flag <= (ul_flag && !stat_clr) || (|ul_enter);
      tw_flag <= |tw_cmp;
    end
  end

  AST_OC_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_flag && !stat_clr) |=> oc_flag); // R10
  AST_UL_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ul_flag && !stat_clr) |=> ul_flag); // R10
  AST_TW_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (|tw_cmp) |=> tw_flag); // R9
  AST_TW_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !(|tw_cmp) |=> !tw_flag); // R9
endmodule

// File: tb/hb_fault_tracker_bench.sv
`timescale 1ns/1ps
module hb_fault_tracker_bench;
  localparam int N  = 6;
  localparam int OC = 6;
  localparam int UL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] br_en = '0, oc_cmp = '0, ul_cmp = '0, tw_cmp = '0, tsd_cmp = '0;
  logic ul_shut_en = 1'b0, stat_clr = 1'b0;
  logic [2*N-1:0] br_status;
  logic oc_flag, ul_flag, tsd_flag, tw_flag;
  logic [N-1:0] latch_off;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hb_fault_tracker #(.NUM_BR(N), .OC_DLY(OC), .UL_DLY(UL)) u_hb_fault_tracker (
    .clk(clk), .rst_n(rst_n), .br_en(br_en), .oc_cmp(oc_cmp), .ul_cmp(ul_cmp),
    .tw_cmp(tw_cmp), .tsd_cmp(tsd_cmp), .ul_shut_en(ul_shut_en), .stat_clr(stat_clr),
    .br_status(br_status), .oc_flag(oc_flag), .ul_flag(ul_flag), .tsd_flag(tsd_flag),
    .tw_flag(tw_flag), .latch_off(latch_off)
  );

  // {br_en, tw_cmp, expected br_status, expected tw_flag}
  localparam logic [24:0] VEC [6] = '{
    {6'b000001, 6'b000000, 12'b000000000011, 1'b0},
    {6'b101010, 6'b000100, 12'b110011001100, 1'b1},
    {6'b111111, 6'b100000, 12'b111111111111, 1'b1},
    {6'b010101, 6'b000000, 12'b001100110011, 1'b0},
    {6'b110000, 6'b000001, 12'b111100000000, 1'b1},
    {6'b000000, 6'b000000, 12'b000000000000, 1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] st(input int i);
    return br_status[2*i +: 2];
  endfunction

  task automatic pulse_clr();
    stat_clr = 1'b1; step(1); stat_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R1 status", 32'(br_status), 0);
    chk("R1 flags", {oc_flag, ul_flag, tsd_flag, tw_flag}, 0);
    chk("R1 latch_off", 32'(latch_off), 0);
    rst_n = 1'b1; step(1);

    for (int v = 0; v < 6; v++) begin
      br_en = VEC[v][24:19]; tw_cmp = VEC[v][18:13];
      step(1);
      chk("R2 table status", 32'(br_status), 32'(VEC[v][12:1]));
      chk("R9 table tw_flag", 32'(tw_flag), 32'(VEC[v][0]));
    end

    br_en = '1; step(1);
    chk("R2 all enabled", 32'(br_status), 32'hFFF);

    // R3 persistence
    oc_cmp[0] = 1'b1; step(OC - 1);
    chk("R3 before delay", st(0), 2'b11);
    step(1);
    chk("R3 after delay", st(0), 2'b01);
    chk("R3 latch_off", latch_off[0], 1);
    chk("R3 oc_flag", oc_flag, 1);
    oc_cmp[0] = 1'b0;
    oc_cmp[1] = 1'b1; step(OC - 1); oc_cmp[1] = 1'b0; step(1);
    oc_cmp[1] = 1'b1; step(OC - 1);
    chk("R3 gap restarts", st(1), 2'b11);
    oc_cmp[1] = 1'b0;

    pulse_clr();
    chk("R7 clear status", st(0), 2'b11);
    chk("R7 clear flag", oc_flag, 0);
    chk("R7 clear latch", 32'(latch_off), 0);

    // R4 shared timer, R5 report only
    ul_cmp[1] = 1'b1; step(5);
    ul_cmp[2] = 1'b1; step(UL - 6);
    chk("R4 before expiry", {st(2), st(1)}, 4'b1111);
    step(1);
    chk("R4 shared expiry", {st(2), st(1)}, 4'b1010);
    chk("R4 ul_flag", ul_flag, 1);
    chk("R5 report only", latch_off[1], 0);

    // R6 escalation and no reverse path
    oc_cmp[1] = 1'b1; step(OC);
    chk("R6 escalate", st(1), 2'b01);
    oc_cmp[1] = 1'b0; step(UL + 2);
    chk("R6 no reverse", st(1), 2'b01);
    ul_cmp = '0;
    pulse_clr();
    chk("R7 clear both", {st(2), st(1)}, 4'b1111);
    chk("R7 flags", {oc_flag, ul_flag}, 0);

    // R4 restart
    ul_cmp[3] = 1'b1; step(UL - 2); ul_cmp[3] = 1'b0; step(1);
    ul_cmp[3] = 1'b1; step(UL - 1);
    chk("R4 restart", st(3), 2'b11);
    step(1);
    chk("R4 after restart", st(3), 2'b10);
    ul_cmp[3] = 1'b0;
    pulse_clr();

    // R5 shutdown control
    ul_shut_en = 1'b1; ul_cmp[4] = 1'b1; step(UL);
    chk("R5 ul status", st(4), 2'b10);
    chk("R5 latch off", latch_off[4], 1);
    oc_cmp[4] = 1'b1; step(OC + 1);
    chk("R5 latched no escalate", st(4), 2'b10);
    oc_cmp[4] = 1'b0; ul_cmp[4] = 1'b0; ul_shut_en = 1'b0;

    // R10 sticky after disable
    oc_cmp[5] = 1'b1; step(OC);
    chk("R10 oc", st(5), 2'b01);
    oc_cmp[5] = 1'b0; br_en[5] = 1'b0; step(1);
    chk("R2 disable from oc", st(5), 2'b00);
    chk("R10 flag sticky", oc_flag, 1);
    chk("R2 latch released", latch_off[5], 0);
    br_en[5] = 1'b1; step(1);
    chk("R2 re-enable", st(5), 2'b11);
    pulse_clr();
    chk("R7 all released", 32'(latch_off), 0);
    chk("R7 all on", 32'(br_status), 32'hFFF);

    // R7 same-edge conflict
    oc_cmp[0] = 1'b1; step(OC - 1);
    stat_clr = 1'b1; step(1); stat_clr = 1'b0;
    chk("R7 oc wins", st(0), 2'b01);
    chk("R7 oc flag wins", oc_flag, 1);
    oc_cmp[0] = 1'b0;
    pulse_clr();

    // R8 thermal latch
    tsd_cmp[2] = 1'b1; step(1);
    chk("R8 latch", latch_off[2], 1);
    chk("R8 flag", tsd_flag, 1);
    chk("R8 status unchanged", st(2), 2'b11);
    pulse_clr();
    chk("R8 hot clear ignored", tsd_flag, 1);
    tsd_cmp[2] = 1'b0; step(1);
    chk("R8 stays latched", latch_off[2], 1);
    pulse_clr();
    chk("R8 cool clear", {tsd_flag, latch_off[2]}, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule